// File: doc/BRIEF.md
# Cartridge Segment Overlay Mapper

This block overlays dock and extension-ROM space onto a 64 KB processor address space cut into eight 8 KB segments. For every memory access it decides whether the segment is served by the normal (home) mapping or by an alternate one. For alternate segments it also supplies a page number, a reworked address bit 13, cartridge select lines and a write strobe that may be suppressed. Software sets it up through three I/O ports. A segment-mask port holds one bit per segment. A bank port picks dock or extension ROM for all alternate segments. A table port takes sixteen writes to fill one entry per dock segment and one per extension-ROM segment.

A table write carries its configuration in two places. The data byte is the page number. The upper half of the I/O address holds the entry index, an A13 handling mode, an external-select enable and a write-protect flag. The A13 mode decides which 8 KB half of a 16 KB bank the segment reaches. The segment can reach its natural half, the opposite half, or always the same half from every segment. All outputs come from registers, so the result for an address presented in one cycle is available in the next cycle.

Top module: `cart_seg_mapper`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `alt_o`, `dock_cs_o`, `exrom_cs_o`, `mem_wr_o` and `page_o` are 0. Reset clears the segment mask, the bank bit and every table entry. After reset an entry that has not been written reads as page 0, mode pass, no select and no protection.
- R2: A write to I/O port low byte 0xF4 loads the segment mask from the data byte. Mask bit n set places segment n (`cpu_addr_i[15:13]` == n) in the alternate mapping, and `alt_o` reports this.
- R3: A write to port low byte 0xFF loads the bank bit from data bit 7. Data bits 6:0 are ignored. Bank 0 makes alternate segments use dock entries 0..7. Bank 1 makes them use extension-ROM entries 8..15. The entry used is index {bank, segment}.
- R4: A write to port low byte 0xD4 stores one table entry at the index given by `io_addr_i[11:8]`, with page = data byte. The page appears on `page_o` for an alternate segment that uses that entry.
- R5: `io_addr_i[13:12]` of a table write sets the entry's A13 mode: 00 passes `cpu_addr_i[13]`, 01 inverts it, 10 forces 0, 11 forces 1. The result drives `hi_addr_o[0]`.
- R6: `io_addr_i[14]` of a table write enables the external select. In an alternate segment whose entry has it set, `dock_cs_o` is asserted when the bank is 0 and `exrom_cs_o` when the bank is 1. Neither is ever asserted in a home segment.
- R7: `io_addr_i[15]` of a table write marks the entry write-protected. In an alternate segment using such an entry, `mem_wr_o` stays 0 even when `cpu_wr_i` is 1. In every other case `mem_wr_o` follows `cpu_wr_i`. Reads see the same page and address as unprotected segments.
- R8: Every output reflects the `cpu_addr_i` and `cpu_wr_i` sampled at the previous rising clock edge. This is a latency of one cycle.
- R9: When a table write and a lookup of the same entry happen in the same cycle, the lookup returns the entry's previous contents. The next lookup returns the new contents.
- R10: Writes to any other port low byte change nothing. Home segments output page 0 and pass `cpu_addr_i[13]` unchanged. `hi_addr_o[2:1]` always equals the previous cycle's `cpu_addr_i[15:14]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | 16 | I/O port address (low byte selects port, high byte carries configuration) |
| io_data_i | input | 8 | I/O write data |
| cpu_addr_i | input | 16 | Memory access address |
| cpu_wr_i | input | 1 | Memory write request |
| page_o | output | 8 | Page number bus for the alternate mapping |
| hi_addr_o | output | 3 | Converted address bits 15:13 (bit 0 is converted A13) |
| alt_o | output | 1 | Access falls in the alternate mapping |
| dock_cs_o | output | 1 | External dock cartridge select |
| exrom_cs_o | output | 1 | External extension-ROM cartridge select |
| mem_wr_o | output | 1 | Gated memory write strobe |

## Verification
A table write and a lookup of the very entry being written can fall in the same cycle. So can a segment-mask write and a lookup in the segment it changes. The bench drives the table port and the memory address on the same clock edge for one entry. It expects the old page and mode on that cycle and the new ones on the lookup that follows. The scoreboard models the table as read-before-write, and judges both outputs against that model.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  localparam int PAGE_W   = 8;
  localparam int SEG_BITS = 3;
  localparam int TBL_AW   = SEG_BITS + 1;
  localparam int TBL_N    = 1 << TBL_AW;

  localparam logic [7:0] PORT_SEGMASK = 8'hF4;
  localparam logic [7:0] PORT_BANK    = 8'hFF;
  localparam logic [7:0] PORT_TABLE   = 8'hD4;

  typedef enum logic [1:0] {
    A13_PASS = 2'b00,
    A13_INV  = 2'b01,
    A13_LOW  = 2'b10,
    A13_HIGH = 2'b11
  } a13_mode_e;

  typedef struct packed {
    logic              wprot;
    logic              ext_en;
    a13_mode_e         mode;
    logic [PAGE_W-1:0] page;
  } seg_entry_t;

endpackage

// File: rtl/cms_cfg_decode.sv
module cms_cfg_decode
  import cart_map_pkg::*;
#(
  parameter int NSEG = 1 << SEG_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_data,
  output logic [NSEG-1:0]   seg_mask,
  output logic              bank_sel,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_waddr,
  output seg_entry_t        tbl_wdata
);

  logic hit_mask, hit_bank;

  assign hit_mask = io_wr && (io_addr[7:0] == PORT_SEGMASK);
  assign hit_bank = io_wr && (io_addr[7:0] == PORT_BANK);
  assign tbl_we   = io_wr && (io_addr[7:0] == PORT_TABLE);

  // Table index and per-entry flags sit in the high address byte
  assign tbl_waddr        = io_addr[8 +: TBL_AW];
  assign tbl_wdata.wprot  = io_addr[15];
  assign tbl_wdata.ext_en = io_addr[14];
  assign tbl_wdata.mode   = a13_mode_e'(io_addr[13:12]);
  assign tbl_wdata.page   = io_data[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_mask <= '0;
      bank_sel <= 1'b0;
    end else begin
      if (hit_mask) seg_mask <= io_data[NSEG-1:0];
      if (hit_bank) bank_sel <= io_data[7];
    end
  end

endmodule

// File: rtl/cms_seg_table.sv
module cms_seg_table
  import cart_map_pkg::*;
#(
  parameter int DEPTH = TBL_N,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  seg_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output seg_entry_t    rdata
);

  // Storage without reset so it can map onto RAM; a written-flag vector
  // supplies the cleared state after reset.
  seg_entry_t       mem [DEPTH];
  seg_entry_t       rd_q;
  logic [DEPTH-1:0] written;
  logic             written_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      written_q <= written[raddr];
      if (we) written[waddr] <= 1'b1;
    end
  end

  assign rdata = written_q ? rd_q : '0;

endmodule

// File: rtl/cms_a13_conv.sv
module cms_a13_conv
  import cart_map_pkg::*;
(
  input  a13_mode_e mode,
  input  logic      a13_in,
  output logic      a13_out
);

  always_comb begin
    unique case (mode)
      A13_PASS: a13_out = a13_in;
      A13_INV:  a13_out = ~a13_in;
      A13_LOW:  a13_out = 1'b0;
      A13_HIGH: a13_out = 1'b1;
      default:  a13_out = a13_in;
    endcase
  end

endmodule

// File: rtl/cart_seg_mapper.sv
module cart_seg_mapper
  import cart_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int NSEG  = 1 << SEG_BITS,
  localparam int SEG_LO = ADDR_W - SEG_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr_i,
  input  logic [15:0]       io_addr_i,
  input  logic [7:0]        io_data_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_wr_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [2:0]        hi_addr_o,
  output logic              alt_o,
  output logic              dock_cs_o,
  output logic              exrom_cs_o,
  output logic              mem_wr_o
);

  logic [NSEG-1:0]     alt_mask;
  logic                bank_sel;
  logic                tbl_we;
  logic [TBL_AW-1:0]   tbl_waddr;
  seg_entry_t          tbl_wdata;
  seg_entry_t          entry;

  logic [SEG_BITS-1:0] seg_now;
  logic [TBL_AW-1:0]   tbl_raddr;

  logic                alt_q, bank_q, wr_q;
  logic [2:0]          ahi_q;
  logic                a13_conv;

  cms_cfg_decode #(.NSEG(NSEG)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .io_wr     (io_wr_i),
    .io_addr   (io_addr_i),
    .io_data   (io_data_i),
    .seg_mask  (alt_mask),
    .bank_sel  (bank_sel),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .tbl_wdata (tbl_wdata)
  );

  assign seg_now   = cpu_addr_i[SEG_LO +: SEG_BITS];
  assign tbl_raddr = {bank_sel, seg_now};

  cms_seg_table #(.DEPTH(TBL_N)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_raddr),
    .rdata (entry)
  );

  // Lookup stage registers, aligned with the table's registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      alt_q  <= 1'b0;
      bank_q <= 1'b0;
      wr_q   <= 1'b0;
      ahi_q  <= '0;
    end else begin
      alt_q  <= alt_mask[seg_now];
      bank_q <= bank_sel;
      wr_q   <= cpu_wr_i;
      ahi_q  <= cpu_addr_i[ADDR_W-1 -: 3];
    end
  end

  cms_a13_conv u_a13 (
    .mode    (alt_q ? entry.mode : A13_PASS),
    .a13_in  (ahi_q[0]),
    .a13_out (a13_conv)
  );

  assign page_o     = alt_q ? entry.page : '0;
  assign hi_addr_o  = {ahi_q[2:1], a13_conv};
  assign alt_o      = alt_q;
  assign dock_cs_o  = alt_q && entry.ext_en && !bank_q;
  assign exrom_cs_o = alt_q && entry.ext_en &&  bank_q;
  assign mem_wr_o   = wr_q && !(alt_q && entry.wprot);

endmodule

// File: rtl/cart_seg_mapper_chk.sv
module cart_seg_mapper_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_wr_i,
  input logic [15:0] io_addr_i,
  input logic [7:0]  io_data_i,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_wr_i,
  input logic [7:0]  page_o,
  input logic [2:0]  hi_addr_o,
  input logic        alt_o,
  input logic        dock_cs_o,
  input logic        exrom_cs_o,
  input logic        mem_wr_o,
  input logic [7:0]  alt_mask,
  input logic        bank_sel
);

  logic arm;
  always_ff @(posedge clk) begin
    if (rst) arm <= 1'b0;
    else     arm <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!alt_o && !dock_cs_o && !exrom_cs_o && !mem_wr_o && page_o == 8'h00));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    arm && $past(io_wr_i && io_addr_i[7:0] == 8'hF4) |-> alt_mask == $past(io_data_i));

  p_alt_follow_r2: assert property (@(posedge clk) disable iff (rst)
    arm |-> alt_o == $past(alt_mask[cpu_addr_i[15:13]]));

  p_bank_load_r3: assert property (@(posedge clk) disable iff (rst)
    arm && $past(io_wr_i && io_addr_i[7:0] == 8'hFF) |-> bank_sel == $past(io_data_i[7]));

  p_sel_in_alt_r6: assert property (@(posedge clk) disable iff (rst)
    (dock_cs_o || exrom_cs_o) |-> (alt_o && !(dock_cs_o && exrom_cs_o)));

  p_wr_origin_r7: assert property (@(posedge clk) disable iff (rst)
    arm && mem_wr_o |-> $past(cpu_wr_i));

  p_home_wr_r7: assert property (@(posedge clk) disable iff (rst)
    arm && !alt_o |-> mem_wr_o == $past(cpu_wr_i));

  p_hi_pass_r10: assert property (@(posedge clk) disable iff (rst)
    arm |-> hi_addr_o[2:1] == $past(cpu_addr_i[15:14]));

  p_home_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    arm && !alt_o |-> (page_o == 8'h00 && hi_addr_o[0] == $past(cpu_addr_i[13])));

endmodule

bind cart_seg_mapper cart_seg_mapper_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_wr_i    (io_wr_i),
  .io_addr_i  (io_addr_i),
  .io_data_i  (io_data_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wr_i   (cpu_wr_i),
  .page_o     (page_o),
  .hi_addr_o  (hi_addr_o),
  .alt_o      (alt_o),
  .dock_cs_o  (dock_cs_o),
  .exrom_cs_o (exrom_cs_o),
  .mem_wr_o   (mem_wr_o),
  .alt_mask   (alt_mask),
  .bank_sel   (bank_sel)
);

// File: tb/cart_seg_mapper_bench.sv
`timescale 1ns/1ps
module cart_seg_mapper_bench;

  typedef struct packed {
    logic [7:0] page;
    logic [2:0] hi;
    logic       alt;
    logic       dock;
    logic       exr;
    logic       wr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  page_o;
  logic [2:0]  hi_addr_o;
  logic        alt_o, dock_cs_o, exrom_cs_o, mem_wr_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // Reference model state
  logic [7:0]  m_mask;
  logic        m_bank;
  logic [11:0] m_tbl [16];

  exp_t  q_exp [$];
  int    q_due [$];
  string q_tag [$];

  always #4 clk = ~clk;

  cart_seg_mapper u_cart_seg_mapper (
    .clk(clk), .rst(rst), .io_wr_i(io_wr), .io_addr_i(io_addr), .io_data_i(io_data),
    .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr), .page_o(page_o), .hi_addr_o(hi_addr_o),
    .alt_o(alt_o), .dock_cs_o(dock_cs_o), .exrom_cs_o(exrom_cs_o), .mem_wr_o(mem_wr_o)
  );

  task automatic model_clear();
    m_mask = '0;
    m_bank = 1'b0;
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
  endtask

  task automatic model_apply(input logic [15:0] a, input logic [7:0] d);
    case (a[7:0])
      8'hF4: m_mask = d;
      8'hFF: m_bank = d[7];
      8'hD4: m_tbl[a[11:8]] = {a[15:12], d};
      default: ;
    endcase
  endtask

  function automatic exp_t predict(input logic [15:0] a, input logic w);
    exp_t e;
    logic [2:0]  seg;
    logic [11:0] ent;
    logic        alt;
    seg = a[15:13];
    alt = m_mask[seg];
    ent = alt ? m_tbl[{m_bank, seg}] : 12'h000;
    e.alt  = alt;
    e.page = ent[7:0];
    case (ent[9:8])
      2'b00: e.hi = {a[15:14], a[13]};
      2'b01: e.hi = {a[15:14], ~a[13]};
      2'b10: e.hi = {a[15:14], 1'b0};
      default: e.hi = {a[15:14], 1'b1};
    endcase
    e.dock = alt && ent[10] && !m_bank;
    e.exr  = alt && ent[10] &&  m_bank;
    e.wr   = w && !(alt && ent[11]);
    return e;
  endfunction

  task automatic push(input exp_t e, input string tag);
    q_exp.push_back(e);
    q_due.push_back(cyc + 1);
    q_tag.push_back(tag);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    model_apply(a, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] a, input logic w, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wr = w;
    push(predict(a, w), tag);
  endtask

  // Table write and lookup on the same edge: model is read-before-write
  task automatic clash(input logic [15:0] ia, input logic [7:0] d,
                       input logic [15:0] a, input string tag);
    @(negedge clk);
    io_wr = 1'b1; io_addr = ia; io_data = d;
    cpu_addr = a; cpu_wr = 1'b0;
    push(predict(a, 1'b0), tag);
    model_apply(ia, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic drain();
    while (q_exp.size() > 0) @(negedge clk);
  endtask

  // Monitor: pops expected items on their due cycle
  always @(posedge clk) begin
    exp_t act;
    cyc++;
    #2;
    while (q_exp.size() > 0 && q_due[0] == cyc) begin
      act = {page_o, hi_addr_o, alt_o, dock_cs_o, exrom_cs_o, mem_wr_o};
      checks++;
      if (act !== q_exp[0]) begin
        errors++;
        $display("FAIL %s: actual page=%h hi=%b alt=%b dock=%b exr=%b wr=%b expected page=%h hi=%b alt=%b dock=%b exr=%b wr=%b",
                 q_tag[0], act.page, act.hi, act.alt, act.dock, act.exr, act.wr,
                 q_exp[0].page, q_exp[0].hi, q_exp[0].alt, q_exp[0].dock, q_exp[0].exr, q_exp[0].wr);
      end
      void'(q_exp.pop_front());
      void'(q_due.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cpu_wr = 1'b1;
    model_clear();
    repeat (3) @(negedge clk);
    checks++;
    if ({alt_o, dock_cs_o, exrom_cs_o, mem_wr_o, page_o} !== 12'h000) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%h expected=000",
               {alt_o, dock_cs_o, exrom_cs_o, mem_wr_o, page_o});
    end
    rst = 1'b0;
    cpu_wr = 1'b0;
  endtask

  initial begin
    model_clear();
    do_reset();

    lookup(16'hE000, 1'b1, "R1 home after reset");
    lookup(16'h2000, 1'b0, "R10 home passes a13");

    // R4 fill all sixteen entries: mode = index[1:0], ext on 3/11, wprot on 2/10
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = {(i == 2 || i == 10) ? 1'b1 : 1'b0, (i == 3 || i == 11) ? 1'b1 : 1'b0,
           2'(i), 4'(i), 8'hD4};
      io_write(a, 8'h80 + 8'(i));
    end
    lookup(16'h0123, 1'b1, "R2 mask clear keeps home");

    io_write(16'h00F4, 8'h5F);
    io_write(16'h00F5, 8'h00);   // R10 non-port write ignored
    lookup(16'h0123, 1'b0, "R4 R5 dock seg0 pass");
    lookup(16'h3456, 1'b0, "R5 dock seg1 invert");
    lookup(16'h4000, 1'b1, "R7 dock seg2 write blocked");
    lookup(16'h5FFF, 1'b0, "R7 dock seg2 read");
    lookup(16'h6000, 1'b0, "R6 R5 dock seg3 force1 select");
    lookup(16'h9FFF, 1'b1, "R2 seg4 alternate write");
    lookup(16'hA000, 1'b1, "R10 seg5 home");
    lookup(16'hC000, 1'b0, "R2 seg6 alternate");
    lookup(16'hE000, 1'b1, "R10 seg7 home");
    lookup(16'h6000, 1'b0, "R8 back-to-back 1");
    lookup(16'h0000, 1'b1, "R8 back-to-back 2");
    lookup(16'h2000, 1'b1, "R8 back-to-back 3");

    io_write(16'h00FF, 8'h7F);
    lookup(16'h2000, 1'b0, "R3 bank low bits ignored");
    io_write(16'h00FF, 8'h80);
    lookup(16'h2000, 1'b0, "R3 ext seg1 invert");
    lookup(16'h4000, 1'b1, "R3 R7 ext seg2 write blocked");
    lookup(16'h6000, 1'b0, "R6 ext seg3 exrom select");
    lookup(16'hA000, 1'b1, "R6 home no select");

    clash(16'h29D4, 8'h33, 16'h2000, "R9 same-cycle lookup old");
    lookup(16'h2000, 1'b0, "R9 next lookup new");
    clash(16'h00F4, 8'h20, 16'hA000, "R9 mask change same cycle");
    lookup(16'hA000, 1'b1, "R2 seg5 now alternate");
    drain();

    do_reset();
    io_write(16'h00F4, 8'hFF);
    lookup(16'h2000, 1'b1, "R1 table cleared by reset");
    lookup(16'h6000, 1'b0, "R1 bank cleared by reset");
    drain();
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule